// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator. The accumulator is kept as two 32-bit halves: `accHi` holds bits 63:32 and `accLo` holds bits 31:0. A select input chooses between two forms. The long form multiplies two full 32-bit words. The word form multiplies the low 16 bits of each operand. When the saturation mode input is set, the sum is clamped, and each form clamps in its own way.

A processor pipeline drives the unit. It preloads or clears the halves through the direct write ports, then issues a one-cycle start strobe with the operands. The updated halves appear two clock edges later, together with a one-cycle done pulse. While an accumulation is in flight, a second start and any direct writes are dropped. A clear always wins.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset, `accHi` and `accLo` are zero and `donePulse` is low.
- R2: With `opWord`=0 (long form) and `satMode`=0, both 32-bit operands are taken as signed and multiplied into a 64-bit product. The product is added to {accHi,accLo}, and the sum wraps modulo 2^64.
- R3: With `opWord`=1 (word form) and `satMode`=0, only bits 15:0 of each operand are used, taken as signed. The 64-bit sum wraps modulo 2^64.
- R4: In the long form with `satMode`=1, a sum with bit 63 set gets bits 31:16 of the high half forced to ones. A sum with bit 63 clear gets bits 31:15 of the high half cleared. The low half is always the low 32 bits of the sum.
- R5: In the word form with `satMode`=1, a sum below -2^31 leaves the high half at 1 and the low half at 0x80000000.
- R6: In the word form with `satMode`=1, a sum above 2^31-1 leaves the high half at 1 and the low half at 0x7FFFFFFF.
- R7: In the word form with `satMode`=1, a sum from -2^31 to 2^31-1 inclusive is written back as the unmodified 64-bit sum.
- R8: `startIn` samples the operands, `opWord` and `satMode` at a rising edge. Both halves change at the next rising edge, and `donePulse` is high for exactly the one cycle after that edge. A start seen while an accumulation is pending is ignored.
- R9: `clearIn` zeroes both halves at the next edge. It takes priority over a completing accumulation and over direct writes. The done pulse of a cleared accumulation still occurs.
- R10: With no accumulation accepted or pending, `wrHiEn`/`wrLoEn` load `wrHiData`/`wrLoData` into the matching half at the next edge. In the cycle a start is accepted, or while an accumulation is pending, direct writes are ignored.
- R11: With no start, no clear, no write and nothing pending, both halves hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | One-cycle request to accumulate |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opWord | input | 1 | 0: 32x32 long form, 1: 16x16 word form |
| satMode | input | 1 | 1: apply saturation to the sum |
| clearIn | input | 1 | Zero both accumulator halves |
| wrHiEn | input | 1 | Load the high half |
| wrHiData | input | 32 | Data for the high half |
| wrLoEn | input | 1 | Load the low half |
| wrLoData | input | 32 | Data for the low half |
| accHi | output | 32 | Accumulator bits 63:32 |
| accLo | output | 32 | Accumulator bits 31:0 |
| donePulse | output | 1 | High for one cycle when a result is written |

## Verification
The properties assume that every done pulse comes from a start strobe two edges earlier. They also assume that `opWord` and `satMode` still hold, at that pulse, the values they had in the start cycle. Two cases break that relation: a start dropped while the unit is busy, and a clear landing on the completing edge. The saturation shape checks therefore exclude a clear in the previous cycle. The stimulus issues starts only as single-cycle strobes, and holds mode inputs at their sampled values until the result appears. The bench deliberately issues one start while the unit is busy, and that is the only one. The idle-hold property assumes no start, write or clear is driven, and the bench returns all controls to zero between operations.

// File: rtl/mac_pkg.sv
package mac_pkg;
  parameter int HALF_W  = 32;
  parameter int SHORT_W = 16;
  localparam int ACC_W  = 2 * HALF_W;

  typedef struct packed {
    logic captureOps;
    logic commitAcc;
    logic loadHi;
    logic loadLo;
    logic clearAcc;
  } macStrobes_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        clearIn,
  input  logic        wrHiEn,
  input  logic        wrLoEn,
  output macStrobes_t strobes,
  output logic        accBusy,
  output logic        donePulse
);
  logic pending;
  logic acceptStart;

  assign acceptStart = startIn && !pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      pending   <= acceptStart;
      donePulse <= pending;
    end
  end

  always_comb begin
    strobes.captureOps = acceptStart;
    strobes.commitAcc  = pending;
    strobes.loadHi     = wrHiEn && !pending && !acceptStart;
    strobes.loadLo     = wrLoEn && !pending && !acceptStart;
    strobes.clearAcc   = clearIn;
  end

  assign accBusy = pending;
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
  parameter int HALF_W  = 32,
  parameter int SHORT_W = 16,
  localparam int ACC_W  = 2 * HALF_W
) (
  input  logic [ACC_W-1:0] sumIn,
  input  logic             wordForm,
  input  logic             satOn,
  output logic [ACC_W-1:0] resultOut
);
  localparam logic [HALF_W-1:0] NEG_FILL  = {{(HALF_W-SHORT_W){1'b1}}, {SHORT_W{1'b0}}};
  localparam logic [HALF_W-1:0] POS_KEEP  = {{(HALF_W-SHORT_W+1){1'b0}}, {(SHORT_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] MARKER    = HALF_W'(1);
  localparam logic [HALF_W-1:0] LO_MAX    = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] LO_MIN    = {1'b1, {(HALF_W-1){1'b0}}};

  logic [HALF_W-1:0] sumHi;
  logic [HALF_W-1:0] sumLo;
  logic              sumNeg;
  logic              inRange;

  assign sumHi   = sumIn[ACC_W-1:HALF_W];
  assign sumLo   = sumIn[HALF_W-1:0];
  assign sumNeg  = sumIn[ACC_W-1];
  assign inRange = (&sumIn[ACC_W-1:HALF_W-1]) || !(|sumIn[ACC_W-1:HALF_W-1]);

  always_comb begin
    resultOut = sumIn;
    if (satOn) begin
      if (!wordForm) begin
        if (sumNeg) resultOut = {sumHi | NEG_FILL, sumLo};
        else        resultOut = {sumHi & POS_KEEP, sumLo};
      end else if (!inRange) begin
        if (sumNeg) resultOut = {MARKER, LO_MIN};
        else        resultOut = {MARKER, LO_MAX};
      end
    end
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  macStrobes_t       strobes,
  input  logic [HALF_W-1:0] opA,
  input  logic [HALF_W-1:0] opB,
  input  logic              opWord,
  input  logic              satMode,
  input  logic [HALF_W-1:0] wrHiData,
  input  logic [HALF_W-1:0] wrLoData,
  output logic [HALF_W-1:0] accHi,
  output logic [HALF_W-1:0] accLo
);
  logic [HALF_W-1:0] opAReg;
  logic [HALF_W-1:0] opBReg;
  logic              wordReg;
  logic              satReg;
  logic [ACC_W-1:0]  extA;
  logic [ACC_W-1:0]  extB;
  logic [ACC_W-1:0]  product;
  logic [ACC_W-1:0]  sum;
  logic [ACC_W-1:0]  satResult;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAReg  <= '0;
      opBReg  <= '0;
      wordReg <= 1'b0;
      satReg  <= 1'b0;
    end else if (strobes.captureOps) begin
      opAReg  <= opA;
      opBReg  <= opB;
      wordReg <= opWord;
      satReg  <= satMode;
    end
  end

  always_comb begin
    if (wordReg) begin
      extA = {{(ACC_W-SHORT_W){opAReg[SHORT_W-1]}}, opAReg[SHORT_W-1:0]};
      extB = {{(ACC_W-SHORT_W){opBReg[SHORT_W-1]}}, opBReg[SHORT_W-1:0]};
    end else begin
      extA = {{HALF_W{opAReg[HALF_W-1]}}, opAReg};
      extB = {{HALF_W{opBReg[HALF_W-1]}}, opBReg};
    end
  end

  assign product = extA * extB;
  assign sum     = {accHi, accLo} + product;

  mac_saturate #(.HALF_W(HALF_W), .SHORT_W(SHORT_W)) u_sat (
    .sumIn    (sum),
    .wordForm (wordReg),
    .satOn    (satReg),
    .resultOut(satResult)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHi <= '0;
      accLo <= '0;
    end else if (strobes.clearAcc) begin
      accHi <= '0;
      accLo <= '0;
    end else if (strobes.commitAcc) begin
      accHi <= satResult[ACC_W-1:HALF_W];
      accLo <= satResult[HALF_W-1:0];
    end else begin
      if (strobes.loadHi) accHi <= wrHiData;
      if (strobes.loadLo) accLo <= wrLoData;
    end
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [HALF_W-1:0] opA,
  input  logic [HALF_W-1:0] opB,
  input  logic              opWord,
  input  logic              satMode,
  input  logic              clearIn,
  input  logic              wrHiEn,
  input  logic [HALF_W-1:0] wrHiData,
  input  logic              wrLoEn,
  input  logic [HALF_W-1:0] wrLoData,
  output logic [HALF_W-1:0] accHi,
  output logic [HALF_W-1:0] accLo,
  output logic              donePulse
);
  macStrobes_t strobes;
  logic        accBusy;

  mac_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .clearIn  (clearIn),
    .wrHiEn   (wrHiEn),
    .wrLoEn   (wrLoEn),
    .strobes  (strobes),
    .accBusy  (accBusy),
    .donePulse(donePulse)
  );

  mac_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .opWord  (opWord),
    .satMode (satMode),
    .wrHiData(wrHiData),
    .wrLoData(wrLoData),
    .accHi   (accHi),
    .accLo   (accLo)
  );
endmodule

// File: rtl/mac_sat_checker.sv
module mac_sat_checker
  import mac_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic              opWord,
  input logic              satMode,
  input logic              clearIn,
  input logic              wrHiEn,
  input logic              wrLoEn,
  input logic              accBusy,
  input logic [HALF_W-1:0] accHi,
  input logic [HALF_W-1:0] accLo,
  input logic              donePulse
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse); // R8
  AST_DONE_FROM_START: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> $past(startIn, 2)); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (accHi == '0 && accLo == '0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!startIn && !accBusy && !clearIn && !wrHiEn && !wrLoEn) |=> ($stable(accHi) && $stable(accLo))); // R11
  AST_LONG_SAT_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && $past(!opWord && satMode, 2) && !$past(clearIn))
      |-> (accHi[HALF_W-1:SHORT_W] == '1 || accHi[HALF_W-1:SHORT_W-1] == '0)); // R4
  AST_WORD_SAT_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && $past(opWord && satMode, 2) && !$past(clearIn))
      |-> (accHi == {HALF_W{accLo[HALF_W-1]}} ||
           (accHi == HALF_W'(1) && (accLo == {1'b1, {(HALF_W-1){1'b0}}} ||
                                    accLo == {1'b0, {(HALF_W-1){1'b1}}})))); // R7
endmodule

bind mac_sat_unit mac_sat_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startIn  (startIn),
  .opWord   (opWord),
  .satMode  (satMode),
  .clearIn  (clearIn),
  .wrHiEn   (wrHiEn),
  .wrLoEn   (wrLoEn),
  .accBusy  (accBusy),
  .accHi    (accHi),
  .accLo    (accLo),
  .donePulse(donePulse)
);

// File: tb/mac_sat_unit_bench.sv
`timescale 1ns/1ps
module mac_sat_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        opWord = 1'b0;
  logic        satMode = 1'b0;
  logic        clearIn = 1'b0;
  logic        wrHiEn = 1'b0;
  logic [31:0] wrHiData = '0;
  logic        wrLoEn = 1'b0;
  logic [31:0] wrLoData = '0;
  logic [31:0] accHi;
  logic [31:0] accLo;
  logic        donePulse;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mac_sat_unit u_mac_sat_unit (.*);

  typedef struct packed {
    logic [31:0] hi, lo, a, b;
    logic        word, sat;
    logic [31:0] expHi, expLo;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0, 32'h0, 32'd3, 32'd5, 1'b0, 1'b0, 32'h0, 32'hF},                           // R2
    '{32'h0, 32'h0, 32'hFFFFFFFE, 32'd7, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFF2},     // R2
    '{32'h7FFFFFFF, 32'hFFFFFFFF, 32'd1, 32'd1, 1'b0, 1'b0, 32'h80000000, 32'h0},     // R2
    '{32'h0, 32'h0, 32'h80000000, 32'h80000000, 1'b0, 1'b0, 32'h40000000, 32'h0},     // R2
    '{32'h0, 32'h0, 32'h12340003, 32'hABCD0004, 1'b1, 1'b0, 32'h0, 32'hC},            // R3
    '{32'h0, 32'h0, 32'h0000FFFF, 32'd5, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFB},     // R3
    '{32'h80000000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 32'hFFFF0000, 32'h0},            // R4
    '{32'h12345678, 32'h9, 32'd2, 32'd3, 1'b0, 1'b1, 32'h00005678, 32'hF},            // R4
    '{32'h0, 32'h0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b1, 32'h00007FFF, 32'h1},     // R4
    '{32'h0, 32'h7FFFFFFF, 32'd1, 32'd1, 1'b1, 1'b1, 32'h1, 32'h7FFFFFFF},            // R6
    '{32'h1, 32'h0, 32'h0, 32'h0, 1'b1, 1'b1, 32'h1, 32'h7FFFFFFF},                   // R6
    '{32'hFFFFFFFF, 32'h80000000, 32'h0000FFFF, 32'd1, 1'b1, 1'b1, 32'h1, 32'h80000000}, // R5
    '{32'hFFFFFFFF, 32'hFFFFFFF0, 32'd4, 32'd5, 1'b1, 1'b1, 32'h0, 32'h4},            // R7
    '{32'h0, 32'h0, 32'h00008000, 32'h00008000, 1'b1, 1'b1, 32'h0, 32'h40000000}      // R7
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadAcc(input logic [31:0] hi, input logic [31:0] lo);
    @(negedge clk);
    wrHiEn = 1'b1; wrHiData = hi; wrLoEn = 1'b1; wrLoData = lo;
    @(negedge clk);
    wrHiEn = 1'b0; wrLoEn = 1'b0;
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic w, input logic s);
    @(negedge clk);
    startIn = 1'b1; opA = a; opB = b; opWord = w; satMode = s;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset acc", {accHi, accLo}, 64'h0);
    check("R1 reset done", {63'h0, donePulse}, 64'h0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      loadAcc(VECS[i].hi, VECS[i].lo);
      check("R10 direct load", {accHi, accLo}, {VECS[i].hi, VECS[i].lo});
      issue(VECS[i].a, VECS[i].b, VECS[i].word, VECS[i].sat);
      check("R8 acc unchanged while pending", {accHi, accLo}, {VECS[i].hi, VECS[i].lo});
      @(negedge clk);
      check("R8 done pulse", {63'h0, donePulse}, 64'h1);
      check($sformatf("R2-R7 vector %0d", i), {accHi, accLo}, {VECS[i].expHi, VECS[i].expLo});
      @(negedge clk);
      check("R8 done width", {63'h0, donePulse}, 64'h0);
    end

    // R10: writes while pending are ignored; R8: start while pending ignored
    loadAcc(32'h0, 32'h0);
    issue(32'd2, 32'd3, 1'b0, 1'b0);
    wrHiEn = 1'b1; wrHiData = 32'hDEAD0000; wrLoEn = 1'b1; wrLoData = 32'h0000BEEF;
    startIn = 1'b1; opA = 32'd100; opB = 32'd100;
    @(negedge clk);
    wrHiEn = 1'b0; wrLoEn = 1'b0; startIn = 1'b0;
    check("R10 write ignored while busy", {accHi, accLo}, 64'd6);
    check("R8 done", {63'h0, donePulse}, 64'h1);
    @(negedge clk);
    check("R8 busy start dropped (no done)", {63'h0, donePulse}, 64'h0);
    @(negedge clk);
    check("R8 busy start dropped (acc)", {accHi, accLo}, 64'd6);
    check("R11 idle hold", {accHi, accLo}, 64'd6);

    // R10: write in the start-accept cycle is ignored
    @(negedge clk);
    startIn = 1'b1; opA = 32'd1; opB = 32'd1; wrLoEn = 1'b1; wrLoData = 32'h55;
    @(negedge clk);
    startIn = 1'b0; wrLoEn = 1'b0;
    @(negedge clk);
    check("R10 write ignored at start", {accHi, accLo}, 64'd7);

    // R9: clear wins over completing accumulation
    loadAcc(32'h0, 32'd10);
    issue(32'd1, 32'd1, 1'b0, 1'b0);
    clearIn = 1'b1;
    @(negedge clk);
    clearIn = 1'b0;
    check("R9 clear beats commit", {accHi, accLo}, 64'h0);
    check("R9 done still pulses", {63'h0, donePulse}, 64'h1);

    // R9: clear beats direct write
    loadAcc(32'h1234, 32'h5678);
    @(negedge clk);
    clearIn = 1'b1; wrHiEn = 1'b1; wrHiData = 32'hFFFF; wrLoEn = 1'b1; wrLoData = 32'hFFFF;
    @(negedge clk);
    clearIn = 1'b0; wrHiEn = 1'b0; wrLoEn = 1'b0;
    check("R9 clear beats write", {accHi, accLo}, 64'h0);

    // R10: single-half write
    @(negedge clk);
    wrHiEn = 1'b1; wrHiData = 32'hA5A5A5A5;
    @(negedge clk);
    wrHiEn = 1'b0;
    check("R10 high-half only", {accHi, accLo}, {32'hA5A5A5A5, 32'h0});
    repeat (3) @(negedge clk);
    check("R11 hold over idle cycles", {accHi, accLo}, {32'hA5A5A5A5, 32'h0});

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule